// File: doc/BRIEF.md
# Countdown Timer Bank

The block gives a host four separate 24-bit down-counters for short, precise intervals, and a seconds counter for long, coarse intervals such as aging out stale table entries. Each down-counter has its own reload value, enable, one-shot or periodic mode, and a rate select. The rate select picks every clock cycle, every 16th cycle or every 256th cycle. When a down-counter reaches zero it sets a sticky expiry flag, and that flag drives the interrupt line for that counter.

Software reaches the block through a single-cycle register write strobe and a combinational read port. The address is five bits wide. Bit 4 clear selects a timer register: bits 3:2 hold the timer index and bits 1:0 hold the register (0 reload, 1 control, 2 live count, 3 status). Address 0x10 reads the seconds counter. All other addresses read as zero. The rate dividers run freely from one counter on the single clock and produce one-cycle enables, so no derived clock exists.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, every count, reload, control and status register reads zero, the seconds counter reads zero and all interrupt outputs are low.
- R2: A write to a timer's reload register (reg 0) loads the value into both the reload register and the live count in the same cycle and clears that timer's expiry flag.
- R3: An enabled timer with rate select 0 decrements its count by one on every clock cycle. Control reg 1 has bit 0 for enable, bit 1 for periodic and bits 3:2 for rate.
- R4: Rate select 1 decrements once every 16 cycles and rate select 2 (or 3) decrements once every 256 cycles.
- R5: The step from one to zero sets the sticky expiry flag (status reg 3, bit 0) and raises that timer's interrupt. A one-shot timer then stays at zero.
- R6: In periodic mode the step that would reach zero instead reloads the reload value, and counting continues.
- R7: A disabled timer holds its count.
- R8: Writing 1 to status bit 0 clears the flag. Writing 0 has no effect. An expiry in the same cycle as a clear leaves the flag set.
- R9: Writes to one timer do not change the count or flag of any other timer.
- R10: The seconds counter (address 0x10) increases by exactly one every CYCLES_PER_SEC clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single system clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| addr | input | 5 | Register address for both read and write |
| wrData | input | 24 | Write data |
| rdData | output | 32 | Combinational read data for addr |
| irq | output | 4 | Per-timer interrupt, equal to the expiry flag |

## Verification
The hardest case to reach is a status clear that lands on the very edge at which the same timer expires. The bench reaches it by running the timer at full rate from a small reload value. Because every register write takes a known number of negative edges, the clear strobe can be issued so that it meets the edge where the count goes from one to zero. The divided rates depend on the free-running divider's phase, which the ports cannot see, so the bench counts decrements over whole multiples of the division period.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int NUM_TIMERS = 4;
  localparam int CNT_W      = 24;
  localparam int SEL_W      = $clog2(NUM_TIMERS);
  localparam int REG_W      = 2;
  localparam int ADDR_W     = SEL_W + REG_W + 1;
  localparam int DIV_MID    = 4;   // log2 of the middle rate divisor
  localparam int DIV_W      = 8;   // log2 of the slow rate divisor

  localparam logic [ADDR_W-1:0] SEC_ADDR = ADDR_W'(1) << (ADDR_W - 1);

  typedef enum logic [1:0] {
    PS_FULL = 2'd0,
    PS_MID  = 2'd1,
    PS_SLOW = 2'd2,
    PS_ALT  = 2'd3
  } presc_e;

  typedef enum logic [REG_W-1:0] {
    REG_RELOAD = 2'd0,
    REG_CTRL   = 2'd1,
    REG_COUNT  = 2'd2,
    REG_STAT   = 2'd3
  } treg_e;

  typedef struct packed {
    logic [NUM_TIMERS-1:0] loadWr;
    logic [NUM_TIMERS-1:0] ctrlWr;
    logic [NUM_TIMERS-1:0] flagClr;
    logic [CNT_W-1:0]      data;
  } tmr_strobe_t;
endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int RTC_W = 32
) (
  input  logic                             wrEn,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [CNT_W-1:0]                 wrData,
  input  logic [NUM_TIMERS-1:0][CNT_W-1:0] tmrCnt,
  input  logic [NUM_TIMERS-1:0][CNT_W-1:0] tmrRld,
  input  logic [NUM_TIMERS-1:0]            tmrEn,
  input  logic [NUM_TIMERS-1:0]            tmrPer,
  input  logic [NUM_TIMERS-1:0]            tmrFlag,
  input  presc_e [NUM_TIMERS-1:0]          tmrPsel,
  input  logic [RTC_W-1:0]                 rtcSec,
  output tmr_strobe_t                      stb,
  output logic [RTC_W-1:0]                 rdData
);
  logic             isTimer;
  logic [SEL_W-1:0] sel;
  treg_e            regSel;

  assign isTimer = !addr[ADDR_W-1];
  assign sel     = addr[REG_W+SEL_W-1:REG_W];
  assign regSel  = treg_e'(addr[REG_W-1:0]);

  // Write decode into per-timer strobes
  always_comb begin
    stb.data    = wrData;
    stb.loadWr  = '0;
    stb.ctrlWr  = '0;
    stb.flagClr = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (wrEn && isTimer && sel == SEL_W'(i)) begin
        stb.loadWr[i]  = (regSel == REG_RELOAD);
        stb.ctrlWr[i]  = (regSel == REG_CTRL);
        stb.flagClr[i] = (regSel == REG_STAT) && wrData[0];
      end
    end
  end

  // Read multiplexer
  always_comb begin
    rdData = '0;
    if (isTimer) begin
      unique case (regSel)
        REG_RELOAD: rdData = RTC_W'(tmrRld[sel]);
        REG_CTRL:   rdData = RTC_W'({tmrPsel[sel], tmrPer[sel], tmrEn[sel]});
        REG_COUNT:  rdData = RTC_W'(tmrCnt[sel]);
        REG_STAT:   rdData = RTC_W'(tmrFlag[sel]);
        default:    rdData = '0;
      endcase
    end else if (addr == SEC_ADDR) begin
      rdData = rtcSec;
    end
  end
endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int CYCLES_PER_SEC = 100_000_000,
  parameter int RTC_W          = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  tmr_strobe_t                      stb,
  output logic [NUM_TIMERS-1:0][CNT_W-1:0] tmrCnt,
  output logic [NUM_TIMERS-1:0][CNT_W-1:0] tmrRld,
  output logic [NUM_TIMERS-1:0]            tmrEn,
  output logic [NUM_TIMERS-1:0]            tmrPer,
  output logic [NUM_TIMERS-1:0]            tmrFlag,
  output presc_e [NUM_TIMERS-1:0]          tmrPsel,
  output logic [RTC_W-1:0]                 rtcSec
);
  localparam int SEC_CW = $clog2(CYCLES_PER_SEC);

  // Shared free-running divider producing one-cycle rate enables
  logic [DIV_W-1:0] divCnt;
  logic             tickMid, tickSlow;

  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  assign tickMid  = &divCnt[DIV_MID-1:0];
  assign tickSlow = &divCnt;

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : gTimer
    logic [CNT_W-1:0] cntQ, rldQ;
    logic             enQ, perQ, flagQ;
    presc_e           pselQ;
    logic             rateTick, advance, expire;

    always_comb begin
      unique case (pselQ)
        PS_FULL: rateTick = 1'b1;
        PS_MID:  rateTick = tickMid;
        default: rateTick = tickSlow;
      endcase
    end

    assign advance = enQ && rateTick && (cntQ != '0) && !stb.loadWr[g];
    assign expire  = advance && (cntQ == CNT_W'(1));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ  <= '0;
        rldQ  <= '0;
        enQ   <= 1'b0;
        perQ  <= 1'b0;
        pselQ <= PS_FULL;
        flagQ <= 1'b0;
      end else begin
        if (stb.ctrlWr[g]) begin
          enQ   <= stb.data[0];
          perQ  <= stb.data[1];
          pselQ <= presc_e'(stb.data[3:2]);
        end
        if (stb.loadWr[g]) begin
          cntQ <= stb.data;
          rldQ <= stb.data;
        end else if (expire) begin
          cntQ <= perQ ? rldQ : '0;
        end else if (advance) begin
          cntQ <= cntQ - 1'b1;
        end
        // expiry outranks a clear arriving on the same edge
        if (expire)                               flagQ <= 1'b1;
        else if (stb.loadWr[g] || stb.flagClr[g]) flagQ <= 1'b0;
      end
    end

    assign tmrCnt[g]  = cntQ;
    assign tmrRld[g]  = rldQ;
    assign tmrEn[g]   = enQ;
    assign tmrPer[g]  = perQ;
    assign tmrFlag[g] = flagQ;
    assign tmrPsel[g] = pselQ;
  end

  // Coarse seconds counter
  logic [SEC_CW-1:0] secCyc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secCyc <= '0;
      rtcSec <= '0;
    end else if (secCyc == SEC_CW'(CYCLES_PER_SEC - 1)) begin
      secCyc <= '0;
      rtcSec <= rtcSec + 1'b1;
    end else begin
      secCyc <= secCyc + 1'b1;
    end
  end
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tick_timer_pkg::*;
#(
  parameter int CYCLES_PER_SEC = 100_000_000,
  parameter int RTC_W          = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [CNT_W-1:0]      wrData,
  output logic [RTC_W-1:0]      rdData,
  output logic [NUM_TIMERS-1:0] irq
);
  tmr_strobe_t                      stb;
  logic [NUM_TIMERS-1:0][CNT_W-1:0] tmrCnt, tmrRld;
  logic [NUM_TIMERS-1:0]            tmrEn, tmrPer, tmrFlag;
  presc_e [NUM_TIMERS-1:0]          tmrPsel;
  logic [RTC_W-1:0]                 rtcSec;

  tick_timer_ctrl #(.RTC_W(RTC_W)) ctrlInst (
    .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .tmrCnt(tmrCnt), .tmrRld(tmrRld), .tmrEn(tmrEn), .tmrPer(tmrPer),
    .tmrFlag(tmrFlag), .tmrPsel(tmrPsel), .rtcSec(rtcSec),
    .stb(stb), .rdData(rdData)
  );

  tick_timer_dp #(.CYCLES_PER_SEC(CYCLES_PER_SEC), .RTC_W(RTC_W)) dpInst (
    .clk(clk), .rstN(rstN), .stb(stb),
    .tmrCnt(tmrCnt), .tmrRld(tmrRld), .tmrEn(tmrEn), .tmrPer(tmrPer),
    .tmrFlag(tmrFlag), .tmrPsel(tmrPsel), .rtcSec(rtcSec)
  );

  assign irq = tmrFlag;
endmodule

// File: rtl/tick_timer_bank_chk.sv
module tick_timer_bank_chk
  import tick_timer_pkg::*;
#(
  parameter int RTC_W = 32
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             wrEn,
  input logic [ADDR_W-1:0]                addr,
  input logic                             clrBit,
  input logic [NUM_TIMERS-1:0]            irq,
  input logic [NUM_TIMERS-1:0][CNT_W-1:0] cnt,
  input logic [NUM_TIMERS-1:0]            en,
  input logic [NUM_TIMERS-1:0]            per,
  input logic [RTC_W-1:0]                 sec
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (irq == '0 && sec == '0));

  assert_sec_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sec) |-> (sec == $past(sec) + 1'b1));

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : gChk
    logic loadHit, clrHit;
    assign loadHit = wrEn && addr == ADDR_W'(g * 4);
    assign clrHit  = wrEn && addr == ADDR_W'(g * 4 + 3) && clrBit;

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
      (irq[g] && !loadHit && !clrHit) |=> irq[g]);

    assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (!rstN)
      (!en[g] && !loadHit) |=> $stable(cnt[g]));

    assert_oneshot_rest_R5: assert property (@(posedge clk) disable iff (!rstN)
      (cnt[g] == '0 && !per[g] && !loadHit) |=> (cnt[g] == '0));

    assert_load_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
      loadHit |=> !irq[g]);
  end
endmodule

bind tick_timer_bank tick_timer_bank_chk #(.RTC_W(RTC_W)) chkInst (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .clrBit(wrData[0]),
  .irq(irq), .cnt(tmrCnt), .en(tmrEn), .per(tmrPer), .sec(rtcSec)
);

// File: tb/tick_timer_bank_test.sv
module tick_timer_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPS        = 100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [23:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  tick_timer_bank #(.CYCLES_PER_SEC(CPS), .RTC_W(32)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [4:0] ta(int t, int r);
    return 5'(t * 4 + r);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [4:0] a, logic [23:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic testReset();
    logic [31:0] d;
    for (int t = 0; t < 4; t++) begin
      for (int r = 0; r < 4; r++) begin
        regRead(ta(t, r), d);
        check("R1 register zero after reset", d, 0);
      end
    end
    regRead(5'h10, d);
    check("R1 seconds zero after reset", d, 0);
    check("R1 irq low after reset", 32'(irq), 0);
  endtask

  task automatic testFullRate();
    logic [31:0] d;
    regWrite(ta(0, 0), 24'd10);
    regRead(ta(0, 0), d);
    check("R2 reload readback", d, 10);
    regRead(ta(0, 2), d);
    check("R2 count loaded", d, 10);
    regWrite(ta(0, 1), 24'h1);
    regRead(ta(0, 2), d);
    check("R3 count at enable", d, 10);
    repeat (3) @(negedge clk);
    regRead(ta(0, 2), d);
    check("R3 one step per cycle", d, 7);
    repeat (7) @(negedge clk);
    regRead(ta(0, 2), d);
    check("R5 count reached zero", d, 0);
    regRead(ta(0, 3), d);
    check("R5 expiry flag set", d, 1);
    check("R5 irq0 raised", 32'(irq), 32'h1);
    repeat (5) @(negedge clk);
    regRead(ta(0, 2), d);
    check("R5 one-shot stays at zero", d, 0);
    regRead(ta(3, 2), d);
    check("R9 timer3 count untouched", d, 0);
    regRead(ta(1, 3), d);
    check("R9 timer1 flag untouched", d, 0);
    regWrite(ta(0, 0), 24'd5);
    regRead(ta(0, 3), d);
    check("R2 load clears flag", d, 0);
    regRead(ta(0, 2), d);
    check("R2 count reloaded", d, 5);
    regWrite(ta(0, 1), 24'h0);
  endtask

  task automatic testClear();
    logic [31:0] d;
    regWrite(ta(1, 0), 24'd2);
    regWrite(ta(1, 1), 24'h1);
    regWrite(ta(1, 3), 24'h1);   // lands on the expiry edge
    regRead(ta(1, 3), d);
    check("R8 expiry beats same-cycle clear", d, 1);
    regWrite(ta(1, 3), 24'h0);
    regRead(ta(1, 3), d);
    check("R8 writing zero keeps flag", d, 1);
    regWrite(ta(1, 3), 24'h1);
    regRead(ta(1, 3), d);
    check("R8 writing one clears flag", d, 0);
    check("R8 irq1 low after clear", 32'(irq[1]), 0);
  endtask

  task automatic testPeriodic();
    logic [31:0] d;
    regWrite(ta(2, 0), 24'd3);
    regWrite(ta(2, 1), 24'h3);
    repeat (3) @(negedge clk);
    regRead(ta(2, 2), d);
    check("R6 periodic reload", d, 3);
    regRead(ta(2, 3), d);
    check("R6 periodic flag", d, 1);
    @(negedge clk);
    regRead(ta(2, 2), d);
    check("R6 counting continues", d, 2);
  endtask

  task automatic testHold();
    logic [31:0] d0, d1;
    regWrite(ta(2, 1), 24'h2);
    regRead(ta(2, 2), d0);
    repeat (20) @(negedge clk);
    regRead(ta(2, 2), d1);
    check("R7 disabled count holds", d1, d0);
  endtask

  task automatic testDivided();
    logic [31:0] d0, d1;
    regWrite(ta(3, 0), 24'd1000);
    regWrite(ta(3, 1), 24'h5);
    regRead(ta(3, 2), d0);
    repeat (160) @(negedge clk);
    regRead(ta(3, 2), d1);
    check("R4 divide-by-16 rate", d1, d0 - 10);
    regWrite(ta(3, 1), 24'h9);
    regRead(ta(3, 2), d0);
    repeat (512) @(negedge clk);
    regRead(ta(3, 2), d1);
    check("R4 divide-by-256 rate", d1, d0 - 2);
    regWrite(ta(3, 1), 24'hD);
    regRead(ta(3, 2), d0);
    repeat (512) @(negedge clk);
    regRead(ta(3, 2), d1);
    check("R4 select 3 acts as 256", d1, d0 - 2);
  endtask

  task automatic testSeconds();
    logic [31:0] s0, s1;
    regRead(5'h10, s0);
    repeat (3 * CPS) @(negedge clk);
    regRead(5'h10, s1);
    check("R10 seconds step", s1, s0 + 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFullRate();
    testClear();
    testPeriodic();
    testHold();
    testDivided();
    testSeconds();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule